// File: doc/BRIEF.md
# Repeat-Loop and Next-PC Sequencer

This block sits at the front of a dual-slot processor pipeline. For every 64-bit instruction bundle it decodes the two format bits into a bundle type, decides which slot may issue (and in which order), resolves any jump targets reported by the slots, and selects the next program counter. It runs a zero-overhead hardware repeat loop: when the bundle at the loop-end address completes while the loop is active, control returns to the loop-start address, the trip count is decremented, and the loop-active flag is dropped once the count is exhausted.

An instruction-address breakpoint sits after the loop logic. When the bundle address matches the breakpoint address and the breakpoint-enable bit of the status word is set, the sequencer saves the computed next PC and a copy of the status word (with the exception-active bit added) into debug registers. It then reduces the live status word to supervisor mode plus debug-state, and sends the PC to a fixed debug vector. Loop state is settled before this diversion, so a breakpoint never changes loop state.

The execution units are outside this block: they report jump-valid/target per slot and a first-slot kill. The block takes the loop registers as inputs and returns their updated values. One bundle is processed per cycle while `bnd_valid` is high, and all results are registered.

Top module: `loop_npc_seq`

## Requirements
- R1: The bundle type output equals {bundle[63], bundle[31]}: 3 = long, 0 = parallel pair, 1 = left (bundle[63:32]) then right (bundle[31:0]), 2 = right then left.
- R2: Long issues the left slot only. Parallel issues both slots. In a sequential pair the first slot always issues, and the second issues only if the first reported no jump and `first_kill` is low. `right_first` is 1 only for type 2.
- R3: In parallel mode, if both slots report a jump, `par_err` is 1 and no jump is taken. The next PC follows the loop/sequential rules instead.
- R4: A taken jump has top priority for the next PC. Only an issued slot's jump counts, and in a sequential pair the first slot's jump wins.
- R5: With no jump, if the loop-active flag is set, the count sampled before the bundle is nonzero, and PC equals loop end, then the next PC is loop start.
- R6: The count decrements by one when PC equals loop end and (count > 0 or loop-active is set). It never goes below zero.
- R7: The loop-active flag is cleared when it was set, PC equals loop end, and the count after decrement is zero. Otherwise it keeps its value, and it is never set by this block.
- R8: Otherwise the next PC is PC + 8.
- R9: When PC equals the breakpoint address and status bit 28 is set, `dbg_take` is 1. Then `dbg_pc` takes the computed next PC, `dbg_status` takes the status word with bit 29 set, `status_out` becomes (status & bit31) | bit27, and the next PC is 0xFFFFF128. Otherwise `status_out` equals the status input and the debug outputs are 0.
- R10: After reset all outputs are 0. Registered outputs update only on a cycle with `bnd_valid` high, one clock later, and `out_vld` marks that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bnd_valid | input | 1 | Bundle present this cycle |
| pc_in | input | 32 | Address of the bundle |
| bundle | input | 64 | Instruction bundle word |
| left_jv | input | 1 | Left slot produced a jump target |
| left_jt | input | 32 | Left slot jump target |
| right_jv | input | 1 | Right slot produced a jump target |
| right_jt | input | 32 | Right slot jump target |
| first_kill | input | 1 | First slot of a sequential pair cancels the second |
| loop_start | input | 32 | Repeat loop start address |
| loop_end | input | 32 | Repeat loop end address |
| loop_count | input | 32 | Repeat trip count |
| loop_rp | input | 1 | Repeat-loop active flag |
| brk_addr | input | 32 | Breakpoint instruction address |
| status_in | input | 32 | Status word |
| out_vld | output | 1 | Registered results refer to a bundle |
| btype | output | 2 | Decoded bundle type |
| left_issue | output | 1 | Left slot issues |
| right_issue | output | 1 | Right slot issues |
| right_first | output | 1 | Right slot runs first |
| par_err | output | 1 | Parallel double-jump error |
| next_pc | output | 32 | Selected next PC |
| count_out | output | 32 | Updated trip count |
| rp_out | output | 1 | Updated loop-active flag |
| status_out | output | 32 | Updated status word |
| dbg_take | output | 1 | Breakpoint diversion taken |
| dbg_pc | output | 32 | Saved next PC for the debugger |
| dbg_status | output | 32 | Saved status word for the debugger |

## Verification
The assertions assume that the slot jump and kill inputs are stable for the whole cycle in which `bnd_valid` is high. They also assume that the loop registers on the inputs are the architectural values before the bundle executes. The stimulus drives every input half a cycle before the sampling edge. It places the PC deliberately on the loop-end and breakpoint addresses, at trip counts of 0, 1 and above, so that loop exit, loop-back, saturation and a breakpoint inside a live loop all occur. It also includes idle cycles so that the hold behaviour is exercised.

// File: rtl/loop_npc_pkg.sv
package loop_npc_pkg;
  typedef enum logic [1:0] {
    BT_PAR  = 2'd0,
    BT_LR   = 2'd1,
    BT_RL   = 2'd2,
    BT_LONG = 2'd3
  } btype_e;

  // format bits sit at the top of each 32-bit half
  function automatic logic [1:0] fmt_bits(input logic [63:0] w);
    return {w[63], w[31]};
  endfunction

  // decrement that stops at zero
  function automatic logic [31:0] sat_dec32(input logic [31:0] c, input logic en);
    if (en && (c != '0)) return c - 32'd1;
    return c;
  endfunction
endpackage

// File: rtl/bundle_decode.sv
module bundle_decode
  import loop_npc_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [63:0]   bundle,
  input  logic          l_jv,
  input  logic [AW-1:0] l_jt,
  input  logic          r_jv,
  input  logic [AW-1:0] r_jt,
  input  logic          kill,
  output btype_e        bt,
  output logic          l_iss,
  output logic          r_iss,
  output logic          r_first,
  output logic          jmp_take,
  output logic [AW-1:0] jmp_tgt,
  output logic          par_err
);
  always_comb begin
    bt       = btype_e'(fmt_bits(bundle));
    l_iss    = 1'b0;
    r_iss    = 1'b0;
    r_first  = 1'b0;
    jmp_take = 1'b0;
    jmp_tgt  = '0;
    par_err  = 1'b0;
    unique case (bt)
      BT_LONG: begin
        l_iss    = 1'b1;
        jmp_take = l_jv;
        jmp_tgt  = l_jt;
      end
      BT_LR: begin
        l_iss = 1'b1;
        r_iss = !(l_jv || kill);
        if (l_jv) begin
          jmp_take = 1'b1;
          jmp_tgt  = l_jt;
        end else if (r_iss && r_jv) begin
          jmp_take = 1'b1;
          jmp_tgt  = r_jt;
        end
      end
      BT_RL: begin
        r_first = 1'b1;
        r_iss   = 1'b1;
        l_iss   = !(r_jv || kill);
        if (r_jv) begin
          jmp_take = 1'b1;
          jmp_tgt  = r_jt;
        end else if (l_iss && l_jv) begin
          jmp_take = 1'b1;
          jmp_tgt  = l_jt;
        end
      end
      default: begin
        l_iss = 1'b1;
        r_iss = 1'b1;
        if (l_jv && r_jv) begin
          par_err = 1'b1;
        end else if (l_jv) begin
          jmp_take = 1'b1;
          jmp_tgt  = l_jt;
        end else if (r_jv) begin
          jmp_take = 1'b1;
          jmp_tgt  = r_jt;
        end
      end
    endcase
  end

  // R3
  par_nojump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    par_err |-> !jmp_take);
  // R2
  par_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bundle[63] == 1'b0 && bundle[31] == 1'b0) |-> (l_iss && r_iss));
  // R2
  lr_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bundle[63] == 1'b0 && bundle[31] == 1'b1 && (l_jv || kill)) |-> !r_iss);
  // R2
  rl_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bundle[63] == 1'b1 && bundle[31] == 1'b0 && (r_jv || kill)) |-> !l_iss);
endmodule

// File: rtl/loop_ctrl.sv
module loop_ctrl
  import loop_npc_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] lp_end,
  input  logic [CW-1:0] cnt_in,
  input  logic          rp_in,
  input  logic          jmp_take,
  output logic [CW-1:0] cnt_nxt,
  output logic          rp_nxt,
  output logic          loop_back,
  output logic          at_end,
  output logic          pre_nz
);
  logic dec_en;

  always_comb begin
    at_end    = (pc == lp_end);
    pre_nz    = (cnt_in != '0);
    dec_en    = at_end && (pre_nz || rp_in);
    cnt_nxt   = CW'(sat_dec32(32'(cnt_in), dec_en));
    rp_nxt    = rp_in && !(at_end && (cnt_nxt == '0));
    loop_back = !jmp_take && rp_in && pre_nz && at_end;
  end

  // R6
  cnt_nowrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_nxt <= cnt_in);
  // R7
  rp_never_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rp_nxt |-> rp_in);
  // R5
  back_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    loop_back |-> (pc == lp_end && rp_in));
endmodule

// File: rtl/brk_divert.sv
module brk_divert #(
  parameter int          AW      = 32,
  parameter int          SW      = 32,
  parameter int          SM_BIT  = 31,
  parameter int          EA_BIT  = 29,
  parameter int          DB_BIT  = 28,
  parameter int          DS_BIT  = 27,
  parameter logic [31:0] DBG_VEC = 32'hFFFF_F128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] brk,
  input  logic [SW-1:0] st_in,
  input  logic [AW-1:0] seq_pc,
  output logic          take,
  output logic [AW-1:0] npc,
  output logic [AW-1:0] dpc,
  output logic [SW-1:0] dst,
  output logic [SW-1:0] st_out
);
  localparam logic [SW-1:0] SM_M = SW'(1) << SM_BIT;
  localparam logic [SW-1:0] EA_M = SW'(1) << EA_BIT;
  localparam logic [SW-1:0] DS_M = SW'(1) << DS_BIT;

  always_comb begin
    take   = (pc == brk) && st_in[DB_BIT];
    npc    = take ? AW'(DBG_VEC) : seq_pc;
    dpc    = take ? seq_pc : '0;
    dst    = take ? (st_in | EA_M) : '0;
    st_out = take ? ((st_in & SM_M) | DS_M) : st_in;
  end

  // R9
  vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (npc == AW'(DBG_VEC) && st_out[DS_BIT] && dst[EA_BIT]));
  // R9
  pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take |-> (st_out == st_in && npc == seq_pc));
endmodule

// File: rtl/loop_npc_seq.sv
module loop_npc_seq
  import loop_npc_pkg::*;
#(
  parameter int          AW      = 32,
  parameter int          CW      = 32,
  parameter int          SW      = 32,
  parameter int          STEP    = 8,
  parameter logic [31:0] DBG_VEC = 32'hFFFF_F128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bnd_valid,
  input  logic [AW-1:0] pc_in,
  input  logic [63:0]   bundle,
  input  logic          left_jv,
  input  logic [AW-1:0] left_jt,
  input  logic          right_jv,
  input  logic [AW-1:0] right_jt,
  input  logic          first_kill,
  input  logic [AW-1:0] loop_start,
  input  logic [AW-1:0] loop_end,
  input  logic [CW-1:0] loop_count,
  input  logic          loop_rp,
  input  logic [AW-1:0] brk_addr,
  input  logic [SW-1:0] status_in,
  output logic          out_vld,
  output logic [1:0]    btype,
  output logic          left_issue,
  output logic          right_issue,
  output logic          right_first,
  output logic          par_err,
  output logic [AW-1:0] next_pc,
  output logic [CW-1:0] count_out,
  output logic          rp_out,
  output logic [SW-1:0] status_out,
  output logic          dbg_take,
  output logic [AW-1:0] dbg_pc,
  output logic [SW-1:0] dbg_status
);
  btype_e        d_bt;
  logic          d_li, d_ri, d_rf, d_jt_take, d_err;
  logic [AW-1:0] d_jtgt;
  logic [CW-1:0] l_cnt;
  logic          l_rp, l_back, l_end, l_pnz;
  logic [AW-1:0] seq_pc;
  logic          b_take;
  logic [AW-1:0] b_npc, b_dpc;
  logic [SW-1:0] b_dst, b_st;

  bundle_decode #(.AW(AW)) u_dec (
    .clk(clk), .rst_n(rst_n), .bundle(bundle),
    .l_jv(left_jv), .l_jt(left_jt), .r_jv(right_jv), .r_jt(right_jt),
    .kill(first_kill), .bt(d_bt), .l_iss(d_li), .r_iss(d_ri),
    .r_first(d_rf), .jmp_take(d_jt_take), .jmp_tgt(d_jtgt), .par_err(d_err)
  );

  loop_ctrl #(.AW(AW), .CW(CW)) u_loop (
    .clk(clk), .rst_n(rst_n), .pc(pc_in), .lp_end(loop_end),
    .cnt_in(loop_count), .rp_in(loop_rp), .jmp_take(d_jt_take),
    .cnt_nxt(l_cnt), .rp_nxt(l_rp), .loop_back(l_back),
    .at_end(l_end), .pre_nz(l_pnz)
  );

  always_comb begin
    if (d_jt_take)   seq_pc = d_jtgt;
    else if (l_back) seq_pc = loop_start;
    else             seq_pc = pc_in + AW'(STEP);
  end

  brk_divert #(.AW(AW), .SW(SW), .DBG_VEC(DBG_VEC)) u_brk (
    .clk(clk), .rst_n(rst_n), .pc(pc_in), .brk(brk_addr), .st_in(status_in),
    .seq_pc(seq_pc), .take(b_take), .npc(b_npc), .dpc(b_dpc),
    .dst(b_dst), .st_out(b_st)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld     <= 1'b0;
      btype       <= '0;
      left_issue  <= 1'b0;
      right_issue <= 1'b0;
      right_first <= 1'b0;
      par_err     <= 1'b0;
      next_pc     <= '0;
      count_out   <= '0;
      rp_out      <= 1'b0;
      status_out  <= '0;
      dbg_take    <= 1'b0;
      dbg_pc      <= '0;
      dbg_status  <= '0;
    end else begin
      out_vld <= bnd_valid;
      if (bnd_valid) begin
        btype       <= d_bt;
        left_issue  <= d_li;
        right_issue <= d_ri;
        right_first <= d_rf;
        par_err     <= d_err;
        next_pc     <= b_npc;
        count_out   <= l_cnt;
        rp_out      <= l_rp;
        status_out  <= b_st;
        dbg_take    <= b_take;
        dbg_pc      <= b_dpc;
        dbg_status  <= b_dst;
      end
    end
  end

  // R10
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bnd_valid |=> ($stable(next_pc) && $stable(count_out) && $stable(rp_out)));
  // R4
  jump_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bnd_valid && d_jt_take && !b_take) |=> (next_pc == $past(d_jtgt)));
  // R8
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bnd_valid && !d_jt_take && !l_back && !b_take) |=> (next_pc == $past(pc_in) + AW'(STEP)));
endmodule

// File: tb/test_loop_npc_seq.sv
module test_loop_npc_seq;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bnd_valid = 1'b0;
  logic [31:0] pc_in = '0;
  logic [63:0] bundle = '0;
  logic        left_jv = 1'b0, right_jv = 1'b0, first_kill = 1'b0, loop_rp = 1'b0;
  logic [31:0] left_jt = '0, right_jt = '0, loop_start = '0, loop_end = '0;
  logic [31:0] loop_count = '0, brk_addr = '0, status_in = '0;
  logic        out_vld, left_issue, right_issue, right_first, par_err, rp_out, dbg_take;
  logic [1:0]  btype;
  logic [31:0] next_pc, count_out, status_out, dbg_pc, dbg_status;

  loop_npc_seq i_loop_npc_seq (
    .clk(clk), .rst_n(rst_n), .bnd_valid(bnd_valid), .pc_in(pc_in), .bundle(bundle),
    .left_jv(left_jv), .left_jt(left_jt), .right_jv(right_jv), .right_jt(right_jt),
    .first_kill(first_kill), .loop_start(loop_start), .loop_end(loop_end),
    .loop_count(loop_count), .loop_rp(loop_rp), .brk_addr(brk_addr),
    .status_in(status_in), .out_vld(out_vld), .btype(btype),
    .left_issue(left_issue), .right_issue(right_issue), .right_first(right_first),
    .par_err(par_err), .next_pc(next_pc), .count_out(count_out), .rp_out(rp_out),
    .status_out(status_out), .dbg_take(dbg_take), .dbg_pc(dbg_pc), .dbg_status(dbg_status)
  );

  always #(CLK_P/2) clk = ~clk;

  int n_run = 0, n_fail = 0;

  // expected state
  logic        e_vld = 0, e_li = 0, e_ri = 0, e_rf = 0, e_err = 0, e_rp = 0, e_dbg = 0;
  logic [1:0]  e_bt = 0;
  logic [31:0] e_npc = 0, e_cnt = 0, e_st = 0, e_dpc = 0, e_dst = 0;
  string       e_pc_tag = "R8";

  always @(posedge clk) begin
    if (!rst_n) begin
      e_vld = 0; e_bt = 0; e_li = 0; e_ri = 0; e_rf = 0; e_err = 0; e_npc = 0;
      e_cnt = 0; e_rp = 0; e_st = 0; e_dbg = 0; e_dpc = 0; e_dst = 0;
    end else begin
      e_vld = bnd_valid;
      if (bnd_valid) begin : model
        int kind;
        bit jumped, counted, brk;
        logic [31:0] tgt, seqpc;
        kind = bundle[63] * 2 + bundle[31];
        e_bt = 2'(kind);
        jumped = 0; tgt = 0; e_err = 0; e_rf = (kind == 2);
        if (kind == 3) begin
          e_li = 1; e_ri = 0;
          if (left_jv) begin jumped = 1; tgt = left_jt; end
        end else if (kind == 0) begin
          e_li = 1; e_ri = 1;
          if (left_jv && right_jv) e_err = 1;
          else if (left_jv) begin jumped = 1; tgt = left_jt; end
          else if (right_jv) begin jumped = 1; tgt = right_jt; end
        end else if (kind == 1) begin
          e_li = 1;
          e_ri = !(left_jv || first_kill);
          if (left_jv) begin jumped = 1; tgt = left_jt; end
          else if (e_ri && right_jv) begin jumped = 1; tgt = right_jt; end
        end else begin
          e_ri = 1;
          e_li = !(right_jv || first_kill);
          if (right_jv) begin jumped = 1; tgt = right_jt; end
          else if (e_li && left_jv) begin jumped = 1; tgt = left_jt; end
        end
        counted = (loop_count > 0);
        e_cnt = loop_count;
        if (pc_in == loop_end && (counted || loop_rp) && loop_count > 0) e_cnt = loop_count - 1;
        e_rp = loop_rp && !(pc_in == loop_end && e_cnt == 0);
        if (jumped) begin seqpc = tgt; e_pc_tag = "R4"; end
        else if (loop_rp && counted && pc_in == loop_end) begin seqpc = loop_start; e_pc_tag = "R5"; end
        else begin seqpc = pc_in + 8; e_pc_tag = "R8"; end
        brk = (pc_in == brk_addr) && status_in[28];
        e_dbg = brk;
        if (brk) begin
          e_dpc = seqpc;
          e_dst = status_in | 32'h2000_0000;
          e_st = (status_in & 32'h8000_0000) | 32'h0800_0000;
          e_npc = 32'hFFFF_F128;
          e_pc_tag = "R9";
        end else begin
          e_dpc = 0; e_dst = 0; e_st = status_in; e_npc = seqpc;
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R10 out_vld", 32'(out_vld), 32'(e_vld));
      chk("R1 btype", 32'(btype), 32'(e_bt));
      chk("R2 left_issue", 32'(left_issue), 32'(e_li));
      chk("R2 right_issue", 32'(right_issue), 32'(e_ri));
      chk("R2 right_first", 32'(right_first), 32'(e_rf));
      chk("R3 par_err", 32'(par_err), 32'(e_err));
      chk({e_pc_tag, " next_pc"}, next_pc, e_npc);
      chk("R6 count", count_out, e_cnt);
      chk("R7 rp", 32'(rp_out), 32'(e_rp));
      chk("R9 status_out", status_out, e_st);
      chk("R9 dbg_take", 32'(dbg_take), 32'(e_dbg));
      chk("R9 dbg_pc", dbg_pc, e_dpc);
      chk("R9 dbg_status", dbg_status, e_dst);
    end
  end

  localparam logic [31:0] LS = 32'h0000_1000, LE = 32'h0000_1040, BK = 32'h0000_2000;

  task automatic drive(input logic [1:0] kind, input logic [31:0] pc, input logic lj, input logic rj,
                       input logic kl, input logic [31:0] cnt, input logic rp, input logic [31:0] st);
    @(negedge clk);
    bnd_valid = 1; pc_in = pc;
    bundle = {kind[1], 31'h1234567, kind[0], 31'h7654321};
    left_jv = lj; right_jv = rj; left_jt = 32'h0000_A000; right_jt = 32'h0000_B000;
    first_kill = kl; loop_count = cnt; loop_rp = rp; status_in = st;
  endtask

  initial begin
    #(CLK_P * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    loop_start = LS; loop_end = LE; brk_addr = BK;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 reset next_pc", next_pc, 32'h0);
    chk("R10 reset out_vld", 32'(out_vld), 32'h0);
    chk("R10 reset count", count_out, 32'h0);
    rst_n = 1;
    // R1/R2 each type, plain
    drive(2'd3, 32'h100, 0, 0, 0, 0, 0, 0);
    drive(2'd0, 32'h108, 0, 0, 0, 0, 0, 0);
    drive(2'd1, 32'h110, 0, 0, 0, 0, 0, 0);
    drive(2'd2, 32'h118, 0, 0, 0, 0, 0, 0);
    // R2 skip of second slot by jump and by kill, R4 jump
    drive(2'd1, 32'h120, 1, 1, 0, 0, 0, 0);
    drive(2'd1, 32'h128, 0, 1, 1, 0, 0, 0);
    drive(2'd2, 32'h130, 1, 1, 0, 0, 0, 0);
    drive(2'd2, 32'h138, 1, 0, 0, 0, 0, 0);
    drive(2'd1, 32'h140, 0, 1, 0, 0, 0, 0);
    // R3 parallel double jump, and single jumps
    drive(2'd0, 32'h148, 1, 1, 0, 0, 0, 0);
    drive(2'd0, 32'h150, 0, 1, 0, 0, 0, 0);
    // R3 double jump at loop end: loop-back still applies
    drive(2'd0, LE, 1, 1, 0, 3, 1, 0);
    // R5/R6/R7 loop: count 2, 1, 0
    drive(2'd3, LE, 0, 0, 0, 2, 1, 0);
    drive(2'd3, LE, 0, 0, 0, 1, 1, 0);
    drive(2'd3, LE, 0, 0, 0, 0, 1, 0);
    // R6 decrement without rp, no loop-back
    drive(2'd3, LE, 0, 0, 0, 5, 0, 0);
    // R4 jump beats loop-back at loop end
    drive(2'd3, LE, 1, 0, 0, 4, 1, 0);
    // R9 breakpoint, enabled and disabled, and inside loop
    drive(2'd3, BK, 0, 0, 0, 0, 0, 32'hF000_00FF);
    drive(2'd3, BK, 0, 0, 0, 0, 0, 32'hE000_00FF);
    brk_addr = LE;
    drive(2'd3, LE, 0, 0, 0, 2, 1, 32'h1000_0001);
    brk_addr = BK;
    // R10 idle cycles hold outputs
    @(negedge clk); bnd_valid = 0; pc_in = 32'h5555; loop_count = 9;
    repeat (3) @(negedge clk);
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [31:0] pc;
      int sel;
      sel = $urandom_range(0, 3);
      pc = (sel == 0) ? LE : (sel == 1) ? BK : {20'h0, $urandom_range(0, 4095) & 12'hFF8};
      brk_addr = ($urandom_range(0, 3) == 0) ? LE : BK;
      drive(2'($urandom_range(0, 3)), pc, $urandom_range(0, 3) == 0, $urandom_range(0, 3) == 0,
            $urandom_range(0, 4) == 0, $urandom_range(0, 3), 1'($urandom_range(0, 1)), $urandom);
      bnd_valid = ($urandom_range(0, 5) != 0);
    end
    @(negedge clk); bnd_valid = 0;
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule